// File: doc/BRIEF.md
# Framed Three-Bit Dual Pattern Detector

This block watches a serial bit stream that is cut into fixed frames. A frame is four clock cycles long. In the first three cycles the block takes one bit per rising edge. In the fourth cycle it shows its verdict on two registered flags, and it ignores the input bit of that cycle. One flag reports the triple 0,1,1 and the other reports the triple 1,1,0, each in arrival order. Frames never overlap, and only reset sets where a frame starts: the first rising edge after reset is released takes the first bit of a frame.

The core is a ten-state Moore machine with a fixed four-bit state code. The flags are registered copies of the terminal-state decode. Both target triples are parameters. The default state codes are kept so that the encoding stays fixed. Any state code outside the ten legal ones falls back to idle on the next clock.

Top module: `tri_frame_detector`

## Requirements
- R1: Driving `rst_n` low forces the idle state (code 0000) at once, without waiting for a clock, and clears both flags at once.
- R2: The first rising edge after `rst_n` is released takes the first bit of a frame. Each frame takes three bits on three consecutive edges and then spends one more edge returning to idle, so a new frame starts every four cycles.
- R3: `match_a` is high for exactly the one cycle that follows the edge taking the third bit of a frame, and only when the bits in arrival order are 0,1,1 (`PAT_A` = 3'b011, bit 2 is the first bit to arrive).
- R4: `match_b` is high for exactly the one cycle that follows the edge taking the third bit of a frame, and only when the bits in arrival order are 1,1,0 (`PAT_B` = 3'b110, bit 2 is the first bit to arrive).
- R5: Both flags are low in every other cycle and for every other triple, and they are never high together.
- R6: The input bit in the fourth cycle of a frame has no effect: the next frame's result depends only on that frame's own three bits.
- R7: The state codes are: idle 0000, one bit 0 → 0001, one bit 1 → 0100, bits 00 → 1000, bits 01 → 0011, bits 10 → 1100, bits 11 → 0101. The terminal states are: no match 1101, first triple 0010, second triple 0111.
- R8: Each of the six unused codes (0110, 1001, 1010, 1011, 1110, 1111) leads to idle on the next clock, whatever the input is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low; also sets frame alignment |
| ser_in | input | 1 | Serial data, one bit per rising edge |
| match_a | output | 1 | Registered flag for the first target triple |
| match_b | output | 1 | Registered flag for the second target triple |

## Verification
The checks assume that frame alignment comes only from reset. They also assume that the serial input is settled at each rising edge. The bench therefore changes `ser_in` and `rst_n` only on falling edges, and it releases reset on the same falling edge where it presents a frame's first bit. The assertions also assume that the two pattern parameters differ. The bench keeps the defaults, so each triple can raise at most one flag. The unused state codes cannot be reached through the ports. The bench therefore drives them into a separate copy of the next-state logic.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

    localparam int unsigned STATE_W = 4;
    localparam int unsigned FRAME_BITS = 3;
    localparam int unsigned PREFIX_W = FRAME_BITS - 1;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 4'b0000,
        ST_Z    = 4'b0001,
        ST_O    = 4'b0100,
        ST_ZZ   = 4'b1000,
        ST_ZO   = 4'b0011,
        ST_OZ   = 4'b1100,
        ST_OO   = 4'b0101,
        ST_MISS = 4'b1101,
        ST_HITA = 4'b0010,
        ST_HITB = 4'b0111
    } state_e;

    typedef struct packed {
        state_e state;
        logic   hit_a;
        logic   hit_b;
    } regs_t;

    function automatic logic [PREFIX_W-1:0] prefix_of(input state_e s);
        case (s)
            ST_ZZ:   prefix_of = 2'b00;
            ST_ZO:   prefix_of = 2'b01;
            ST_OZ:   prefix_of = 2'b10;
            default: prefix_of = 2'b11;
        endcase
    endfunction

    function automatic logic is_two_bit(input state_e s);
        is_two_bit = (s == ST_ZZ) || (s == ST_ZO) || (s == ST_OZ) || (s == ST_OO);
    endfunction

endpackage

// File: rtl/tfd_step.sv
module tfd_step
    import tfd_pkg::*;
#(
    parameter logic [FRAME_BITS-1:0] PAT_A = 3'b011,
    parameter logic [FRAME_BITS-1:0] PAT_B = 3'b110
) (
    input  state_e cur,
    input  logic   din,
    output state_e nxt
);

    logic [FRAME_BITS-1:0] word;

    always_comb begin
        word = {prefix_of(cur), din};
        case (cur)
            ST_IDLE: nxt = din ? ST_O : ST_Z;
            ST_Z:    nxt = din ? ST_ZO : ST_ZZ;
            ST_O:    nxt = din ? ST_OO : ST_OZ;
            ST_ZZ, ST_ZO, ST_OZ, ST_OO: begin
                if (word == PAT_A)      nxt = ST_HITA;
                else if (word == PAT_B) nxt = ST_HITB;
                else                    nxt = ST_MISS;
            end
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/tfd_flag_dec.sv
module tfd_flag_dec
    import tfd_pkg::*;
(
    input  state_e st,
    output logic   hit_a,
    output logic   hit_b
);

    always_comb begin
        hit_a = (st == ST_HITA);
        hit_b = (st == ST_HITB);
    end

endmodule

// File: rtl/tri_frame_detector.sv
module tri_frame_detector
    import tfd_pkg::*;
#(
    parameter logic [FRAME_BITS-1:0] PAT_A = 3'b011,
    parameter logic [FRAME_BITS-1:0] PAT_B = 3'b110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic match_a,
    output logic match_b
);

    regs_t  r_d;
    regs_t  r_q;
    state_e nxt_state;
    logic   nxt_a;
    logic   nxt_b;
    state_e state_now;

    tfd_step #(.PAT_A(PAT_A), .PAT_B(PAT_B)) u_step (
        .cur (r_q.state),
        .din (ser_in),
        .nxt (nxt_state)
    );

    tfd_flag_dec u_dec (
        .st    (nxt_state),
        .hit_a (nxt_a),
        .hit_b (nxt_b)
    );

    always_comb begin
        r_d       = r_q;
        r_d.state = nxt_state;
        r_d.hit_a = nxt_a;
        r_d.hit_b = nxt_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, hit_a: 1'b0, hit_b: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_now = r_q.state;
    assign match_a   = r_q.hit_a;
    assign match_b   = r_q.hit_b;

endmodule

// File: rtl/tfd_checker.sv
module tfd_checker
    import tfd_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input state_e state_now,
    input logic   match_a,
    input logic   match_b
);

    logic [1:0] ph_q;
    logic       legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 2'd0;
        else        ph_q <= ph_q + 2'd1;
    end

    always_comb begin
        legal = (state_now == ST_IDLE) || (state_now == ST_Z) || (state_now == ST_O) ||
                is_two_bit(state_now) || (state_now == ST_MISS) ||
                (state_now == ST_HITA) || (state_now == ST_HITB);
    end

    // R2: idle exactly at the start of each four-cycle frame
    a_r2_frame_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == 2'd0) == (state_now == ST_IDLE));

    // R3: first flag follows a two-bit prefix state
    a_r3_hit_a_after_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |-> is_two_bit($past(state_now)));

    // R4: second flag follows a two-bit prefix state
    a_r4_hit_b_after_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        match_b |-> is_two_bit($past(state_now)));

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_a && match_b));

    a_r5_flags_in_last_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a || match_b) |-> (ph_q == 2'd3));

    a_r6_terminal_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == 2'd3) |=> (state_now == ST_IDLE));

    a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        legal);

    a_r8_unused_recovers: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> (state_now == ST_IDLE));

endmodule

bind tri_frame_detector tfd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_now (state_now),
    .match_a   (match_a),
    .match_b   (match_b)
);

// File: tb/tri_frame_detector_bench.sv
module tri_frame_detector_bench;
    import tfd_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic match_a;
    logic match_b;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    state_e step_cur;
    logic   step_din;
    state_e step_nxt;

    always #5 clk = ~clk;

    tri_frame_detector u_tri_frame_detector (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .match_a (match_a),
        .match_b (match_b)
    );

    tfd_step u_step (.cur(step_cur), .din(step_din), .nxt(step_nxt));

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Called on a falling edge; ends on a falling edge with the machine idle.
    task automatic run_frame(input logic b0, input logic b1, input logic b2, input logic b3);
        logic ea;
        logic eb;
        ea = ({b0, b1, b2} == 3'b011);
        eb = ({b0, b1, b2} == 3'b110);
        chk("R5 idle flags", {2'b00, match_a, match_b}, 4'b0000);
        ser_in = b0;
        @(negedge clk);
        chk("R5 flags after bit 1", {2'b00, match_a, match_b}, 4'b0000);
        ser_in = b1;
        @(negedge clk);
        chk("R5 flags after bit 2", {2'b00, match_a, match_b}, 4'b0000);
        ser_in = b2;
        @(negedge clk);
        chk("R3 match_a", {3'b000, match_a}, {3'b000, ea});
        chk("R4 match_b", {3'b000, match_b}, {3'b000, eb});
        ser_in = b3;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        #1;
        chk("R1 reset flags", {2'b00, match_a, match_b}, 4'b0000);
        @(negedge clk);
        chk("R1 flags held in reset", {2'b00, match_a, match_b}, 4'b0000);
        rst_n = 1'b1;
    endtask

    task automatic t_all_triples();
        for (int v = 0; v < 8; v++) begin
            run_frame(v[2], v[1], v[0], 1'b0);
        end
    endtask

    task automatic t_dead_bit_ignored();
        // R6: the fourth-cycle bit must not shift the next frame
        run_frame(1'b0, 1'b1, 1'b1, 1'b1);
        run_frame(1'b1, 1'b1, 1'b0, 1'b1);
        run_frame(1'b1, 1'b1, 1'b0, 1'b0);
        run_frame(1'b0, 1'b1, 1'b1, 1'b0);
        run_frame(1'b1, 1'b0, 1'b1, 1'b1);
        run_frame(1'b0, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_mid_frame_realign();
        // R2: reset inside a frame restarts alignment
        ser_in = 1'b1;
        @(negedge clk);
        ser_in = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 flags in mid-frame reset", {2'b00, match_a, match_b}, 4'b0000);
        rst_n = 1'b1;
        run_frame(1'b0, 1'b1, 1'b1, 1'b0);
        run_frame(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_async_clear();
        ser_in = 1'b1; @(negedge clk);
        ser_in = 1'b1; @(negedge clk);
        ser_in = 1'b0; @(negedge clk);
        chk("R4 flag before async reset", {3'b000, match_b}, 4'b0001);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear", {2'b00, match_a, match_b}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        run_frame(1'b0, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_random_frames();
        for (int k = 0; k < 200; k++) begin
            logic [3:0] r;
            r = 4'($urandom);
            run_frame(r[3], r[2], r[1], r[0]);
        end
    endtask

    task automatic t_step_codes();
        step_cur = ST_IDLE; step_din = 1'b0; #1;
        chk("R7 idle,0", step_nxt, 4'b0001);
        step_din = 1'b1; #1;
        chk("R7 idle,1", step_nxt, 4'b0100);
        step_cur = state_e'(4'b0001); step_din = 1'b1; #1;
        chk("R7 0,1", step_nxt, 4'b0011);
        step_cur = state_e'(4'b0100); step_din = 1'b0; #1;
        chk("R7 1,0", step_nxt, 4'b1100);
        step_cur = state_e'(4'b0011); step_din = 1'b1; #1;
        chk("R7 01,1", step_nxt, 4'b0010);
        step_cur = state_e'(4'b0101); step_din = 1'b0; #1;
        chk("R7 11,0", step_nxt, 4'b0111);
        step_cur = state_e'(4'b1000); step_din = 1'b0; #1;
        chk("R7 00,0", step_nxt, 4'b1101);
        step_cur = state_e'(4'b1101); step_din = 1'b1; #1;
        chk("R7 miss back to idle", step_nxt, 4'b0000);
    endtask

    task automatic t_unused_codes();
        logic [3:0] bad [6];
        bad = '{4'b0110, 4'b1001, 4'b1010, 4'b1011, 4'b1110, 4'b1111};
        for (int i = 0; i < 6; i++) begin
            for (int d = 0; d < 2; d++) begin
                step_cur = state_e'(bad[i]);
                step_din = d[0];
                #1;
                chk("R8 unused code to idle", step_nxt, 4'b0000);
            end
        end
    endtask

    initial begin
        step_cur = ST_IDLE;
        step_din = 1'b0;
        t_step_codes();
        t_unused_codes();
        @(negedge clk);
        t_reset_state();
        t_all_triples();
        t_dead_bit_ignored();
        t_mid_frame_realign();
        t_async_clear();
        t_random_frames();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule